// File: doc/BRIEF.md
# Fractional Real-Time Counter with Compare and Capture Channels

The block is a real-time counter that runs from a slow clock. It keeps two words of time: a whole-seconds word and a fraction-of-a-second word. On each clock cycle in which counting is enabled, a programmable step is added to the fraction. The carry out of that addition advances the seconds. Software can trim the step so that a clock of any rate yields true seconds.

Three channels watch a 32-bit view of the time. This view is built from the low half of the seconds and the high half of the fraction. Channel 0 raises its flag when the view equals its compare word. Channel 1 does the same, or it can switch to capture mode. In capture mode it latches the view on each rising edge of an event input. Channel 2 compares and then moves its own compare word forward by a programmed step, so it fires at a steady period.

All state sits behind a word-addressed register port that is synchronous to the same clock. The event input is taken to be synchronous to that clock as well.

Top module: `frac_rtc`

## Requirements
- R1: After reset every register reads as zero, `bus_rdata` is zero and `evt_flags` is zero.
- R2: While the run bit (bit 0 at 0x00) is 1, each clock adds the step at 0x10 to the fraction at 0x0C modulo 2^32. When that addition wraps, the seconds at 0x08 grow by one on the same edge.
- R3: While the run bit is 0, the seconds and the fraction keep their values.
- R4: A read presents the addressed word on `bus_rdata` one clock after `bus_rd`, and `bus_rdata` holds its value while `bus_rd` is low. The map is 0x00 control, 0x04 flags, 0x08 seconds, 0x0C fraction, 0x10 fraction step, 0x14 channel setup, 0x18/0x1C/0x20 compare words of channels 0/1/2, 0x24 channel 2 step, 0x28 capture word, 0x2C sync and 0x30 time view. The sync word and all unmapped words read as zero.
- R5: The time view at 0x30 is {seconds[15:0], fraction[31:16]}.
- R6: When setup bit n (n = 0..2 at 0x14) is 1 and the time view equals the compare word of channel n, flag bit n (at 0x04 and on `evt_flags`) is 1 from the next edge. When setup bit n is 0, no compare sets the flag.
- R7: Writing 1 to a flag bit clears it and writing 0 leaves it unchanged. If a set and a clear fall on the same edge, the flag stays set.
- R8: When setup bits 1 and 3 are both 1, channel 1 does not compare. Instead, each rising edge of `cap_evt` latches the time view into 0x28 and sets flag 1. When bit 3 is 0, events are not captured.
- R9: Each channel 2 match adds the word at 0x24 to the channel 2 compare word. A software write of that compare word on the same edge takes priority.
- R10: A write to the seconds or the fraction loads that word, overriding the count on that edge. A fraction write discards that edge's carry.
- R11: Writes to the capture word, the sync word and the time view have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | slow counting clock, also the register clock |
| rst | input | 1 | synchronous active-high reset |
| bus_wr | input | 1 | write strobe |
| bus_rd | input | 1 | read strobe |
| bus_addr | input | 6 | byte address; bits 1:0 ignored |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | registered read data |
| cap_evt | input | 1 | capture event for channel 1 |
| evt_flags | output | 3 | channel flags, one bit per channel |

## Verification
The assertions check several properties on every cycle:
- the seconds never move by more than one per edge;
- the counters stand still while stopped;
- a loaded word appears on the next edge;
- a pending set always leaves its flag high, and a lone clear drops it;
- a capture holds the time view of its edge;
- each channel 2 match adds exactly one step;
- read data holds between reads.

Only the bench scenarios can show the exact totals after long runs across fraction wraps, and that the time view uses the right halves. The same holds for how many re-arms occur over a run, for flags staying clear while a channel is disabled or in capture mode, and for read-only words ignoring writes.

// File: rtl/frac_rtc_pkg.sv
package frac_rtc_pkg;
  localparam int ADDR_W = 6;
  localparam int IDX_W  = ADDR_W - 2;
  localparam int NUM_CH = 3;
  localparam int CAP_CH = 1;
  localparam int REARM_CH = 2;
  localparam int CAPMODE_BIT = NUM_CH;
  localparam int CFG_W = NUM_CH + 1;

  localparam logic [IDX_W-1:0] RI_CTRL  = 4'd0;
  localparam logic [IDX_W-1:0] RI_FLAGS = 4'd1;
  localparam logic [IDX_W-1:0] RI_SEC   = 4'd2;
  localparam logic [IDX_W-1:0] RI_FRAC  = 4'd3;
  localparam logic [IDX_W-1:0] RI_INC   = 4'd4;
  localparam logic [IDX_W-1:0] RI_CFG   = 4'd5;
  localparam logic [IDX_W-1:0] RI_CMP0  = 4'd6;
  localparam logic [IDX_W-1:0] RI_STEP2 = 4'd9;
  localparam logic [IDX_W-1:0] RI_CAPT  = 4'd10;
  localparam logic [IDX_W-1:0] RI_SYNC  = 4'd11;
  localparam logic [IDX_W-1:0] RI_TIME  = 4'd12;
endpackage

// File: rtl/frac_rtc_accum.sv
module frac_rtc_accum #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic [W-1:0] inc,
  input  logic         sec_wr,
  input  logic         frac_wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] sec_q,
  output logic [W-1:0] frac_q
);
  logic [W:0] sum;
  assign sum = {1'b0, frac_q} + {1'b0, inc};

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q  <= '0;
      frac_q <= '0;
    end else begin
      if (frac_wr)  frac_q <= wdata;
      else if (run) frac_q <= sum[W-1:0];
      if (sec_wr)   sec_q <= wdata;
      else if (run && sum[W] && !frac_wr) sec_q <= sec_q + 1'b1;
    end
  end

  // R2: seconds move by at most one per edge unless loaded
  a_r2_sec_step: assert property (@(posedge clk) disable iff (rst)
    !sec_wr |=> (sec_q == $past(sec_q)) || (sec_q == $past(sec_q) + 1'b1));
  // R3: stopped counter holds
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (!run && !sec_wr && !frac_wr) |=> ($stable(sec_q) && $stable(frac_q)));
  // R10: a fraction load appears on the next edge
  a_r10_frac_load: assert property (@(posedge clk) disable iff (rst)
    frac_wr |=> frac_q == $past(wdata));
endmodule

// File: rtl/frac_rtc_chan.sv
module frac_rtc_chan #(
  parameter int W = 32,
  parameter bit CAPTURE = 1'b0,
  parameter bit REARM = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         cap_mode,
  input  logic [W-1:0] now,
  input  logic         cmp_wr,
  input  logic         step_wr,
  input  logic [W-1:0] wdata,
  input  logic         evt,
  input  logic         flag_clr,
  output logic [W-1:0] cmp_q,
  output logic [W-1:0] step_q,
  output logic [W-1:0] cap_q,
  output logic         flag_q
);
  logic evt_q, use_cap, hit, rise, set_req;

  assign use_cap = CAPTURE && cap_mode;
  assign hit     = en && !use_cap && (now == cmp_q);
  assign rise    = en && use_cap && evt && !evt_q;
  assign set_req = hit || rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      evt_q <= evt;
      if (set_req)       flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)               cmp_q <= '0;
    else if (cmp_wr)       cmp_q <= wdata;
    else if (REARM && hit) cmp_q <= cmp_q + step_q;
  end

  generate
    if (REARM) begin : g_step
      always_ff @(posedge clk) begin
        if (rst)          step_q <= '0;
        else if (step_wr) step_q <= wdata;
      end
      // R9: each match moves the compare word by one step
      a_r9_rearm: assert property (@(posedge clk) disable iff (rst)
        (hit && !cmp_wr) |=> cmp_q == $past(cmp_q) + $past(step_q));
    end else begin : g_nostep
      logic unused_step;
      assign unused_step = step_wr;
      assign step_q = '0;
    end

    if (CAPTURE) begin : g_cap
      always_ff @(posedge clk) begin
        if (rst)       cap_q <= '0;
        else if (rise) cap_q <= now;
      end
      // R8: a capture holds the time view of its edge
      a_r8_capture: assert property (@(posedge clk) disable iff (rst)
        rise |=> cap_q == $past(now));
    end else begin : g_nocap
      assign cap_q = '0;
    end
  endgenerate

  // R7: set wins, a lone clear drops the flag
  a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
    set_req |=> flag_q);
  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !set_req) |=> !flag_q);
endmodule

// File: rtl/frac_rtc.sv
module frac_rtc
  import frac_rtc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              cap_evt,
  output logic [NUM_CH-1:0] evt_flags
);
  localparam int HALF = DATA_W / 2;

  logic [IDX_W-1:0]  idx;
  logic              unused_lsb;
  logic              run_q;
  logic [CFG_W-1:0]  cfg_q;
  logic [DATA_W-1:0] inc_q, sec_q, frac_q, time_w;
  logic [DATA_W-1:0] cmp_a [NUM_CH];
  logic [DATA_W-1:0] step_a [NUM_CH];
  logic [DATA_W-1:0] cap_a [NUM_CH];
  logic [DATA_W-1:0] step_sel, cap_sel, rd_mux;
  logic [NUM_CH-1:0] flag_v;

  assign idx        = bus_addr[ADDR_W-1:2];
  assign unused_lsb = ^bus_addr[1:0];
  assign time_w     = {sec_q[HALF-1:0], frac_q[DATA_W-1 -: HALF]};

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cfg_q <= '0;
      inc_q <= '0;
    end else if (bus_wr) begin
      if (idx == RI_CTRL) run_q <= bus_wdata[0];
      if (idx == RI_CFG)  cfg_q <= bus_wdata[CFG_W-1:0];
      if (idx == RI_INC)  inc_q <= bus_wdata;
    end
  end

  frac_rtc_accum #(.W(DATA_W)) accum_i (
    .clk(clk), .rst(rst), .run(run_q), .inc(inc_q),
    .sec_wr(bus_wr && idx == RI_SEC), .frac_wr(bus_wr && idx == RI_FRAC),
    .wdata(bus_wdata), .sec_q(sec_q), .frac_q(frac_q)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    frac_rtc_chan #(
      .W(DATA_W), .CAPTURE(c == CAP_CH), .REARM(c == REARM_CH)
    ) chan_i (
      .clk(clk), .rst(rst), .en(cfg_q[c]), .cap_mode(cfg_q[CAPMODE_BIT]),
      .now(time_w),
      .cmp_wr(bus_wr && idx == IDX_W'(RI_CMP0 + c)),
      .step_wr(bus_wr && idx == RI_STEP2),
      .wdata(bus_wdata), .evt(cap_evt),
      .flag_clr(bus_wr && idx == RI_FLAGS && bus_wdata[c]),
      .cmp_q(cmp_a[c]), .step_q(step_a[c]), .cap_q(cap_a[c]), .flag_q(flag_v[c])
    );
  end

  always_comb begin
    step_sel = '0;
    cap_sel  = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      step_sel = step_sel | step_a[c];
      cap_sel  = cap_sel | cap_a[c];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (idx)
      RI_CTRL:  rd_mux = DATA_W'(run_q);
      RI_FLAGS: rd_mux = DATA_W'(flag_v);
      RI_SEC:   rd_mux = sec_q;
      RI_FRAC:  rd_mux = frac_q;
      RI_INC:   rd_mux = inc_q;
      RI_CFG:   rd_mux = DATA_W'(cfg_q);
      RI_STEP2: rd_mux = step_sel;
      RI_CAPT:  rd_mux = cap_sel;
      RI_SYNC:  rd_mux = '0;
      RI_TIME:  rd_mux = time_w;
      default: begin
        for (int c = 0; c < NUM_CH; c++)
          if (idx == IDX_W'(RI_CMP0 + c)) rd_mux = cmp_a[c];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assign evt_flags = flag_v;

  // R4: read data holds between reads
  a_r4_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
  // R6: a disabled channel 0 never raises its flag
  a_r6_disabled: assert property (@(posedge clk) disable iff (rst)
    !cfg_q[0] |=> !$rose(evt_flags[0]));
endmodule

// File: tb/frac_rtc_tb_top.sv
`timescale 1ns/1ps
module frac_rtc_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0, cap_evt = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [2:0] evt_flags;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  frac_rtc dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_evt(cap_evt), .evt_flags(evt_flags)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #500000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] v;
    logic [63:0] acc;
    logic [31:0] incs [4];
    logic [31:0] fr0 [4];
    int lens [4];
    incs = '{32'h1, 32'h8000_0000, 32'hFFFF_FFFF, 32'h1234_5678};
    fr0  = '{32'hFFFF_FFF0, 32'h0, 32'h5, 32'hABCD_0000};
    lens = '{30, 9, 20, 50};

    idle(3);
    rst = 1'b0;
    // R1 reset state
    check("R1 rdata", bus_rdata, 32'h0);
    check("R1 flags port", {29'h0, evt_flags}, 32'h0);
    for (int a = 0; a <= 12; a++) begin
      rd(6'(a * 4), v);
      check("R1 reg zero", v, 32'h0);
    end

    // R4 readback and map
    wr(6'h10, 32'hCAFE_0001); rd(6'h10, v); check("R4 inc", v, 32'hCAFE_0001);
    wr(6'h10, 32'h0);
    wr(6'h18, 32'h1111_2222); rd(6'h18, v); check("R4 cmp0", v, 32'h1111_2222);
    wr(6'h1C, 32'h3333_4444); rd(6'h1C, v); check("R4 cmp1", v, 32'h3333_4444);
    wr(6'h20, 32'h5555_6666); rd(6'h20, v); check("R4 cmp2", v, 32'h5555_6666);
    wr(6'h24, 32'h0000_0777); rd(6'h24, v); check("R4 step2", v, 32'h0000_0777);
    wr(6'h14, 32'h0000_000A); rd(6'h14, v); check("R4 cfg", v, 32'h0000_000A);
    wr(6'h14, 32'h0);
    wr(6'h00, 32'hFFFF_FFFF); rd(6'h00, v); check("R4 ctrl", v, 32'h1);
    wr(6'h00, 32'h0);
    rd(6'h2C, v); check("R4 sync zero", v, 32'h0);
    for (int a = 13; a < 16; a++) begin
      rd(6'(a * 4), v);
      check("R4 unmapped zero", v, 32'h0);
    end
    rd(6'h24, v);
    idle(4);
    check("R4 rdata hold", bus_rdata, 32'h0000_0777);

    // R2 / R3 / R5 accumulation sweep
    for (int i = 0; i < 4; i++) begin
      wr(6'h0C, fr0[i]);
      wr(6'h08, 32'(256 * (i + 1)));
      wr(6'h10, incs[i]);
      wr(6'h00, 32'h1);
      idle(lens[i]);
      wr(6'h00, 32'h0);
      acc = {32'(256 * (i + 1)), fr0[i]} + 64'(lens[i] + 1) * {32'h0, incs[i]};
      rd(6'h08, v); check("R2 seconds", v, acc[63:32]);
      rd(6'h0C, v); check("R2 fraction", v, acc[31:0]);
      idle(8);
      rd(6'h08, v); check("R3 seconds hold", v, acc[63:32]);
      rd(6'h0C, v); check("R3 fraction hold", v, acc[31:0]);
      rd(6'h30, v); check("R5 time view", v, {acc[47:32], acc[31:16]});
    end

    // R10 loads override counting
    wr(6'h10, 32'h1);
    wr(6'h0C, 32'd100);
    wr(6'h08, 32'h0);
    wr(6'h00, 32'h1);
    idle(5);
    wr(6'h0C, 32'd5);
    wr(6'h08, 32'h77);
    wr(6'h00, 32'h0);
    rd(6'h0C, v); check("R10 fraction load", v, 32'd7);
    rd(6'h08, v); check("R10 seconds load", v, 32'h77);

    // R6 / R7 compare and flags
    wr(6'h08, 32'h12);
    wr(6'h0C, 32'h3456_0000);
    wr(6'h18, 32'h0012_3456);
    idle(4);
    rd(6'h04, v); check("R6 disabled no flag", v, 32'h0);
    wr(6'h14, 32'h1);
    idle(2);
    rd(6'h04, v); check("R6 match flag", v, 32'h1);
    check("R6 flag port", {29'h0, evt_flags}, 32'h1);
    wr(6'h04, 32'h1);
    idle(2);
    rd(6'h04, v); check("R7 set wins", v, 32'h1);
    wr(6'h18, 32'h0);
    wr(6'h04, 32'h0);
    idle(2);
    rd(6'h04, v); check("R7 write zero", v, 32'h1);
    wr(6'h04, 32'h1);
    idle(2);
    rd(6'h04, v); check("R7 clear", v, 32'h0);
    wr(6'h1C, 32'h0012_3456);
    wr(6'h14, 32'h2);
    idle(2);
    rd(6'h04, v); check("R6 channel1 flag", v, 32'h2);
    wr(6'h14, 32'h0);
    wr(6'h04, 32'h7);
    idle(2);
    rd(6'h04, v); check("R7 clear all", v, 32'h0);

    // R9 channel 2 re-arm
    wr(6'h08, 32'h0);
    wr(6'h0C, 32'h0);
    wr(6'h10, 32'h0001_0000);
    wr(6'h20, 32'd10);
    wr(6'h24, 32'd7);
    wr(6'h14, 32'h4);
    wr(6'h00, 32'h1);
    idle(39);
    wr(6'h00, 32'h0);
    idle(3);
    rd(6'h30, v); check("R9 time reached", v, 32'd40);
    rd(6'h20, v); check("R9 rearmed compare", v, 32'd45);
    rd(6'h04, v); check("R9 flag", v, 32'h4);
    wr(6'h14, 32'h0);
    wr(6'h04, 32'h7);

    // R8 capture
    wr(6'h08, 32'h00AB);
    wr(6'h0C, 32'hCDEF_0000);
    wr(6'h1C, 32'h00AB_CDEF);
    wr(6'h14, 32'hA);
    idle(3);
    rd(6'h04, v); check("R8 compare suppressed", v, 32'h0);
    cap_evt = 1'b1;
    idle(3);
    cap_evt = 1'b0;
    idle(2);
    rd(6'h28, v); check("R8 captured", v, 32'h00AB_CDEF);
    rd(6'h04, v); check("R8 capture flag", v, 32'h2);
    wr(6'h04, 32'h2);
    wr(6'h0C, 32'h1111_0000);
    wr(6'h14, 32'h2);
    cap_evt = 1'b1;
    idle(3);
    cap_evt = 1'b0;
    idle(2);
    rd(6'h28, v); check("R8 no capture off mode", v, 32'h00AB_CDEF);
    rd(6'h04, v); check("R8 no flag off mode", v, 32'h0);

    // R11 read-only words
    wr(6'h28, 32'hDEAD_0000);
    wr(6'h30, 32'hBEEF_0000);
    wr(6'h2C, 32'h1);
    rd(6'h28, v); check("R11 capture ro", v, 32'h00AB_CDEF);
    rd(6'h30, v); check("R11 time ro", v, 32'h00AB_1111);
    rd(6'h2C, v); check("R11 sync ro", v, 32'h0);

    summary();
  end
endmodule